// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block holds the two threshold offsets used by a FIFO's status flags: the almost-empty offset, counted up from the empty boundary, and the almost-full offset, counted down from the full boundary. The flag comparators read both offsets continuously. The offsets are driven at the width that the FIFO depth needs.

A master reset loads both offsets with the same built-in value. Two select inputs choose that value: 8, 16 or 64 locations. During the same master reset, a mode input chooses how the offsets are reprogrammed later. One method takes them from the write data bus in two enabled write cycles. The other shifts them in one bit per clock through a serial data pin, gated by a serial enable.

A partial reset flushes the FIFO but does not touch the offsets or the chosen method. It only abandons a load that has not finished. The outputs change only when a load is complete, so the flag logic never sees a half-written offset.

Top module: `flag_offset_loader`

## Requirements
- R1: While `mrst` is high at a clock edge, both offsets are set to the default picked by `dflt_sel`: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 64 and 2'b11 gives 64. Both offsets take the same value.
- R2: The value of `ser_mode` at a master reset edge fixes the load method until the next master reset: 1 selects serial loading and 0 selects parallel loading.
- R3: In serial mode, each clock edge with `ser_en` high shifts in one bit from `ser_din`. The first OFS_W bits form the almost-empty offset and the next OFS_W bits form the almost-full offset, each sent most significant bit first. Both outputs update at the edge that takes the last bit.
- R4: Before a load is complete, `ae_ofs` and `af_ofs` keep their previous values.
- R5: In parallel mode, two edges with `wr_en` high make one load. The first takes `wr_data[OFS_W-1:0]` as the almost-empty offset. The second takes the same field as the almost-full offset, and both outputs update at the second edge.
- R6: A partial reset (`prst` high at an edge, `mrst` low) leaves both offsets and the load method unchanged. It discards any bits or first word of a load that has not completed.
- R7: In serial mode `wr_en` has no effect. In parallel mode `ser_en` has no effect.
- R8: In serial mode, an edge with `ser_en` low neither consumes a bit nor disturbs a load in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| dflt_sel | input | 2 | Default offset select, sampled during master reset |
| ser_mode | input | 1 | Load method select, sampled during master reset (1 = serial) |
| ser_en | input | 1 | Serial shift enable |
| ser_din | input | 1 | Serial offset data |
| wr_en | input | 1 | Write enable for parallel loading |
| wr_data | input | DATA_W | Write data bus; the low OFS_W bits carry an offset |
| ae_ofs | output | OFS_W | Almost-empty offset |
| af_ofs | output | OFS_W | Almost-full offset |

## Verification
The assertions check these properties on every cycle:
- both offsets are equal right after a master reset;
- the load method never changes outside a master reset;
- the offsets stay stable in any cycle without a completed load;
- the serial and parallel loaders never complete a load in the same cycle;
- the serial bit count holds while the serial enable is low.

The bench's scenarios show the rest:
- the exact values each select code produces;
- the bit order and word order of both load methods;
- a partial reset dropping a half-finished load without losing the offsets;
- each mode ignoring the other mode's enable.

// File: rtl/flo_pkg.sv
package flo_pkg;

   function automatic int unsigned default_offset(input logic [1:0] code);
      case (code)
         2'b00:   return 8;
         2'b01:   return 16;
         default: return 64;
      endcase
   endfunction

endpackage

// File: rtl/flo_serial_loader.sv
module flo_serial_loader #(
   parameter int OFS_W = 12
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             en,
   input  logic             din,
   output logic             commit,
   output logic [OFS_W-1:0] ae_new,
   output logic [OFS_W-1:0] af_new
);
   localparam int TOTAL = 2 * OFS_W;
   localparam int CNT_W = $clog2(TOTAL);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

   logic [TOTAL-2:0] shreg;
   logic [CNT_W-1:0] cnt;
   logic [TOTAL-1:0] word;

   assign word   = {shreg, din};
   assign commit = en && (cnt == LAST);
   assign ae_new = word[TOTAL-1:OFS_W];
   assign af_new = word[OFS_W-1:0];

   always_ff @(posedge clk) begin
      if (clr) begin
         cnt   <= '0;
         shreg <= '0;
      end else if (en) begin
         cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
         shreg <= word[TOTAL-2:0];
      end
   end

   // R8: the bit count only moves on enabled cycles
   a_r8_hold_count: assert property (@(posedge clk) disable iff (clr)
      !en |=> $stable(cnt));

endmodule

// File: rtl/flo_parallel_loader.sv
module flo_parallel_loader #(
   parameter int OFS_W  = 12,
   parameter int DATA_W = 80
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              en,
   input  logic [DATA_W-1:0] data,
   output logic              commit,
   output logic [OFS_W-1:0]  ae_new,
   output logic [OFS_W-1:0]  af_new
);
   logic             second;
   logic [OFS_W-1:0] stage;

   assign commit = en && second;
   assign ae_new = stage;
   assign af_new = data[OFS_W-1:0];

   always_ff @(posedge clk) begin
      if (clr) begin
         second <= 1'b0;
         stage  <= '0;
      end else if (en) begin
         second <= !second;
         if (!second) stage <= data[OFS_W-1:0];
      end
   end

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader #(
   parameter int DEPTH  = 4096,
   parameter int DATA_W = 80,
   localparam int OFS_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              mrst,
   input  logic              prst,
   input  logic [1:0]        dflt_sel,
   input  logic              ser_mode,
   input  logic              ser_en,
   input  logic              ser_din,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [OFS_W-1:0]  ae_ofs,
   output logic [OFS_W-1:0]  af_ofs
);
   import flo_pkg::*;

   if (DEPTH < 128) begin : g_bad_depth
      $error("flag_offset_loader: DEPTH must hold the largest default offset");
   end
   if (DATA_W < OFS_W) begin : g_bad_width
      $error("flag_offset_loader: DATA_W narrower than offset width");
   end

   logic             mode_q;
   logic             clr;
   logic             s_commit, p_commit;
   logic [OFS_W-1:0] s_ae, s_af, p_ae, p_af;
   logic [OFS_W-1:0] dflt;

   assign clr  = mrst || prst;
   assign dflt = OFS_W'(default_offset(dflt_sel));

   flo_serial_loader #(.OFS_W(OFS_W)) u_ser (
      .clk(clk), .clr(clr), .en(mode_q && ser_en), .din(ser_din),
      .commit(s_commit), .ae_new(s_ae), .af_new(s_af)
   );

   flo_parallel_loader #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_par (
      .clk(clk), .clr(clr), .en(!mode_q && wr_en), .data(wr_data),
      .commit(p_commit), .ae_new(p_ae), .af_new(p_af)
   );

   always_ff @(posedge clk) begin
      if (mrst) begin
         mode_q <= ser_mode;
         ae_ofs <= dflt;
         af_ofs <= dflt;
      end else if (!prst) begin
         if (s_commit) begin
            ae_ofs <= s_ae;
            af_ofs <= s_af;
         end else if (p_commit) begin
            ae_ofs <= p_ae;
            af_ofs <= p_af;
         end
      end
   end

   // R1: a master reset leaves both offsets equal
   a_r1_equal_defaults: assert property (@(posedge clk)
      mrst |=> (ae_ofs == af_ofs));

   // R2: load method only changes at a master reset
   a_r2_mode_kept: assert property (@(posedge clk) disable iff (mrst)
      1'b1 |=> $stable(mode_q));

   // R4: no completed load, no change at the outputs
   a_r4_hold_outputs: assert property (@(posedge clk) disable iff (mrst)
      (!s_commit && !p_commit) |=> ($stable(ae_ofs) && $stable(af_ofs)));

   // R7: only one loader can complete in a cycle
   a_r7_one_loader: assert property (@(posedge clk) disable iff (mrst)
      $onehot0({s_commit, p_commit}));

endmodule

// File: tb/test_flag_offset_loader.sv
`timescale 1ns/1ps
module test_flag_offset_loader;
   localparam int DEPTH  = 4096;
   localparam int DATA_W = 80;
   localparam int W      = $clog2(DEPTH);
   localparam int MASK   = (1 << W) - 1;

   logic              clk = 1'b0;
   logic              mrst = 1'b1, prst = 1'b0;
   logic [1:0]        dflt_sel = 2'b00;
   logic              ser_mode = 1'b0, ser_en = 1'b0, ser_din = 1'b0, wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [W-1:0]      ae_ofs, af_ofs;

   int checks = 0, failures = 0;
   string cur_req = "R1";
   bit started = 0, done = 0;

   // reference model state
   int ref_ae, ref_af, ref_mode, scnt, pph, pstage;
   longint sbits;

   always #2.5 clk = ~clk;

   flag_offset_loader #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_flag_offset_loader (
      .clk(clk), .mrst(mrst), .prst(prst), .dflt_sel(dflt_sel),
      .ser_mode(ser_mode), .ser_en(ser_en), .ser_din(ser_din),
      .wr_en(wr_en), .wr_data(wr_data), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
   );

   always @(posedge clk) begin
      if (mrst) begin
         ref_ae = (dflt_sel == 2'b00) ? 8 : (dflt_sel == 2'b01) ? 16 : 64;
         ref_af = ref_ae;
         ref_mode = ser_mode;
         scnt = 0; sbits = 0; pph = 0;
         started = 1;
      end else if (prst) begin
         scnt = 0; sbits = 0; pph = 0;
      end else if (ref_mode == 1 && ser_en) begin
         sbits = (sbits << 1) | longint'(ser_din);
         scnt++;
         if (scnt == 2 * W) begin
            ref_ae = int'((sbits >> W) & MASK);
            ref_af = int'(sbits & MASK);
            scnt = 0; sbits = 0;
         end
      end else if (ref_mode == 0 && wr_en) begin
         if (pph == 0) begin
            pstage = int'(wr_data[W-1:0]); pph = 1;
         end else begin
            ref_ae = pstage; ref_af = int'(wr_data[W-1:0]); pph = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (started && !done) begin
         checks++;
         if (int'(ae_ofs) != ref_ae || int'(af_ofs) != ref_af) begin
            failures++;
            $display("FAIL %s: ae=%0d af=%0d expected ae=%0d af=%0d",
                     cur_req, ae_ofs, af_ofs, ref_ae, ref_af);
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_mrst(logic [1:0] sel, logic mode, int exp);
      @(negedge clk);
      mrst = 1; dflt_sel = sel; ser_mode = mode;
      @(negedge clk);
      mrst = 0;
      checks++;
      if (int'(ae_ofs) != exp || int'(af_ofs) != exp) begin
         failures++;
         $display("FAIL R1: sel=%0d ae=%0d af=%0d expected %0d", sel, ae_ofs, af_ofs, exp);
      end
   endtask

   task automatic par_write(int v);
      @(negedge clk);
      wr_en = 1; wr_data = {$urandom(), $urandom(), $urandom()};
      wr_data[W-1:0] = W'(v);
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic ser_bits(int v, int nb, bit gaps);
      for (int i = nb - 1; i >= 0; i--) begin
         @(negedge clk);
         ser_en = 1; ser_din = v[i];
         @(negedge clk);
         ser_en = 0;
         if (gaps) begin ser_din = ~ser_din; step(1); end
      end
   endtask

   initial begin
      #(150000 * 5);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      step(2);
      cur_req = "R1";
      do_mrst(2'b00, 0, 8);
      do_mrst(2'b01, 0, 16);
      do_mrst(2'b10, 0, 64);
      do_mrst(2'b11, 0, 64);

      // R5 / R4: parallel loads with idle cycles between writes
      cur_req = "R5";
      par_write(100); step(3); par_write(2000); step(2);
      par_write(4095); par_write(1);
      cur_req = "R7"; // serial enable ignored in parallel mode
      for (int i = 0; i < 30; i++) begin
         @(negedge clk); ser_en = 1; ser_din = i[0];
      end
      @(negedge clk); ser_en = 0;
      // R6: partial reset mid parallel load
      cur_req = "R6";
      par_write(777);
      @(negedge clk); prst = 1; @(negedge clk); prst = 0;
      par_write(333); step(2); par_write(444); step(2);
      @(negedge clk); prst = 1; @(negedge clk); prst = 0;
      par_write(5); par_write(6);

      // R2 / R3: switch to serial mode
      cur_req = "R2";
      do_mrst(2'b01, 1, 16);
      cur_req = "R3";
      ser_bits(1234, W, 0); ser_bits(3210, W, 0);
      cur_req = "R8";
      ser_bits(12'hA5C, W, 1); ser_bits(12'h3F0, W, 1);
      cur_req = "R7"; // write enable ignored in serial mode
      for (int i = 0; i < 6; i++) par_write(i * 50);
      cur_req = "R6";
      ser_bits(12'hFFF, W + 3, 0);
      @(negedge clk); prst = 1; @(negedge clk); prst = 0;
      ser_bits(9, W, 0); ser_bits(17, W, 0);
      @(negedge clk); prst = 1; @(negedge clk); prst = 0;
      cur_req = "R2"; // method survives the partial reset
      ser_bits(42, W, 0); ser_bits(99, W, 0);
      par_write(1); par_write(2);
      cur_req = "R1";
      do_mrst(2'b10, 0, 64);
      cur_req = "R4";
      par_write(12); step(4);
      par_write(13); step(2);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule